// File: doc/BRIEF.md
# Streaming Position Compare Engine

The engine watches a 64-bit position feedback and drives a single output pin when the position crosses a target value. A host writes 32-bit entries into a small circular buffer and then moves a next-write pointer past them. The engine works through the buffer in order, one entry at a time, from its own read pointer. Each entry carries a two-bit kind. It either reloads the pulse-width timer, replaces the upper half of the target, or supplies the lower half and arms a compare. The timer width and the upper half persist between entries. A run of lower-half entries therefore reuses the last upper half and the last width.

An armed compare waits until the selected feedback is at or beyond the target in the tagged direction. When that happens it fires the output action once and the entry is consumed. Every consumed entry of any kind advances a 16-bit event count, which the host reads to learn which slots it may refill.

The output is driven by a three-state machine:
- PS_LOW: the output is low.
- PS_TIMED: a timed pulse is running and a cycle counter is counting down.
- PS_HELD: a position-width pulse is holding the output high.

Its transitions are:
- LOW→TIMED and HELD→TIMED on a timed fire.
- TIMED→TIMED on a retrigger, which reloads the count.
- TIMED→LOW when the count expires.
- LOW→HELD and TIMED→HELD on a position-width fire.
- HELD→LOW on the next position-width fire.
- Any state→LOW while the enable is low.

Top module: `stream_cmp_engine`

## Requirements
- R1: After reset the output is low, the event count is 0, the read pointer is slot 0, and the stored upper half and timer width are both 0.
- R2: When the read pointer equals `wr_ptr`, the buffer is empty. No entry is acted on or consumed, even if a slot has been written.
- R3: Each consumed entry raises `event_count` by exactly one at the clock edge that consumes it. The count wraps from 0xFFFF to 0.
- R4: Kind 0 loads `wr_data[15:0]` as the timer width. Kind 1 loads the upper 32 target bits. Kind 2 is a lower-half compare. Kind 3 is a no-op. Kinds 0, 1 and 3 are consumed in the first enabled cycle they reach the head, without touching the output.
- R5: A compare entry fires at the first clock edge at which the selected position meets its condition. With direction bit 1 the condition is position >= target. With direction bit 0 it is position < target. Until then the entry waits at the head.
- R6: The compare target is {last upper half loaded, entry lower half}.
- R7: With the action bit 0 (timed), the output is high for exactly W cycles starting at the firing edge, where W is the current timer width. A width of 0 gives one cycle.
- R8: A timed fire while a timed pulse is running restarts the count, so the output stays high for W cycles after the second fire.
- R9: With the action bit 1 (position-width), a fire in PS_HELD drives the output low. Otherwise the fire drives it high and holds it there until the next position-width fire.
- R10: A fired compare is consumed. Moving the position back and forth across its target afterwards causes no further count or output change.
- R11: `src_sel` 0 compares `pos_a` and 1 compares `pos_b`.
- R12: While `enable` is low, the read pointer, event count and output are cleared. The upper half and timer width are kept.
- R13: The comparison is made on the two's-complement difference, so it works across rollover. Position 1 is >= target 0xFFFF_FFFF_FFFF_FFFF, and position 0x7FFF_FFFF_FFFF_FFFF is below target 0x8000_0000_0000_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable; low clears read pointer, count, output |
| wr_en | input | 1 | Write strobe for one buffer slot |
| wr_addr | input | PTR_W | Slot written by `wr_en` |
| wr_kind | input | 2 | Entry kind (0 timer, 1 upper, 2 lower/compare, 3 no-op) |
| wr_dir | input | 1 | Compare direction (1: >=, 0: <) |
| wr_posw | input | 1 | Action (0 timed pulse, 1 position-width edge) |
| wr_data | input | 32 | Entry payload |
| wr_ptr | input | PTR_W | Host next-write pointer; slots from read pointer up to it are valid |
| pos_a | input | 64 | Primary position feedback |
| pos_b | input | 64 | Secondary position feedback |
| src_sel | input | 1 | Feedback select |
| cmp_out | output | 1 | Compare output pin |
| event_count | output | CNT_W | Count of consumed entries |

## Verification
The hardest state to reach from the ports is the wrap of the event count. It needs 65,536 consumed entries. The bench fills every slot with no-op entries and then advances `wr_ptr` by one each cycle, so the engine consumes exactly one entry per clock, and it checks the count at 0xFFFF and again at 0. A second hard case is the interaction of a running timed pulse with a new fire, which needs two compares queued behind each other. The bench queues them with adjacent targets and steps the position across the second target partway through the first pulse.

// File: rtl/scmp_pkg.sv
package scmp_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        K_TIMER = 2'd0,
        K_UPPER = 2'd1,
        K_LOWER = 2'd2,
        K_SKIP  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        PS_LOW   = 2'd0,
        PS_TIMED = 2'd1,
        PS_HELD  = 2'd2
    } pstate_e;

    typedef struct packed {
        kind_e              kind;
        logic               dir;
        logic               posw;
        logic [WORD_W-1:0]  data;
    } entry_t;
endpackage

// File: rtl/scmp_buffer.sv
module scmp_buffer
    import scmp_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  entry_t           wr_entry,
    input  logic [PTR_W-1:0] rd_addr,
    output entry_t           rd_entry
);
    entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(g))) begin
                slots[g] <= wr_entry;
            end
        end
    end

    always_comb begin
        rd_entry = slots[rd_addr];
    end
endmodule

// File: rtl/scmp_compare.sv
module scmp_compare #(
    parameter int POS_W = 64
) (
    input  logic [POS_W-1:0] position,
    input  logic [POS_W-1:0] target,
    input  logic             dir,
    output logic             hit
);
    logic [POS_W-1:0] diff;

    always_comb begin
        diff = position - target;
        hit  = dir ? ~diff[POS_W-1] : diff[POS_W-1];
    end
endmodule

// File: rtl/scmp_pulse.sv
module scmp_pulse
    import scmp_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             fire,
    input  logic             fire_posw,
    input  logic [TMR_W-1:0] width,
    output logic             out
);
    pstate_e          state, nstate;
    logic [TMR_W-1:0] tmr, ntmr;

    always_comb begin
        nstate = state;
        ntmr   = tmr;
        unique case (state)
            PS_LOW:   nstate = PS_LOW;
            PS_TIMED: begin
                if (tmr <= TMR_W'(1)) begin
                    nstate = PS_LOW;
                    ntmr   = '0;
                end else begin
                    ntmr = tmr - TMR_W'(1);
                end
            end
            PS_HELD:  nstate = PS_HELD;
            default:  nstate = PS_LOW;
        endcase
        if (fire) begin
            if (fire_posw) begin
                nstate = (state == PS_HELD) ? PS_LOW : PS_HELD;
                ntmr   = '0;
            end else begin
                nstate = PS_TIMED;
                ntmr   = (width == '0) ? TMR_W'(1) : width;
            end
        end
        if (clr) begin
            nstate = PS_LOW;
            ntmr   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_LOW;
            tmr   <= '0;
        end else begin
            state <= nstate;
            tmr   <= ntmr;
        end
    end

    always_comb begin
        out = (state != PS_LOW);
    end
endmodule

// File: rtl/stream_cmp_engine.sv
module stream_cmp_engine
    import scmp_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TMR_W = 16,
    parameter int CNT_W = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int POS_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [1:0]        wr_kind,
    input  logic              wr_dir,
    input  logic              wr_posw,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [POS_W-1:0]  pos_a,
    input  logic [POS_W-1:0]  pos_b,
    input  logic              src_sel,
    output logic              cmp_out,
    output logic [CNT_W-1:0]  event_count
);
    entry_t            wr_entry, head;
    logic [PTR_W-1:0]  rd_ptr;
    logic [WORD_W-1:0] upper_q;
    logic [TMR_W-1:0]  width_q;
    logic [POS_W-1:0]  position;
    logic              pending, hit, consume, fire;

    always_comb begin
        wr_entry.kind = kind_e'(wr_kind);
        wr_entry.dir  = wr_dir;
        wr_entry.posw = wr_posw;
        wr_entry.data = wr_data;
    end

    scmp_buffer #(.DEPTH(DEPTH), .PTR_W(PTR_W)) buf_i (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_entry (wr_entry),
        .rd_addr  (rd_ptr),
        .rd_entry (head)
    );

    always_comb begin
        position = src_sel ? pos_b : pos_a;
        pending  = enable && (rd_ptr != wr_ptr);
    end

    scmp_compare #(.POS_W(POS_W)) cmp_i (
        .position (position),
        .target   ({upper_q, head.data}),
        .dir      (head.dir),
        .hit      (hit)
    );

    always_comb begin
        consume = pending && ((head.kind != K_LOWER) || hit);
        fire    = consume && (head.kind == K_LOWER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr      <= '0;
            event_count <= '0;
            upper_q     <= '0;
            width_q     <= '0;
        end else if (!enable) begin
            rd_ptr      <= '0;
            event_count <= '0;
        end else if (consume) begin
            rd_ptr      <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            event_count <= event_count + CNT_W'(1);
            if (head.kind == K_TIMER) width_q <= head.data[TMR_W-1:0];
            if (head.kind == K_UPPER) upper_q <= head.data;
        end
    end

    scmp_pulse #(.TMR_W(TMR_W)) pulse_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!enable),
        .fire      (fire),
        .fire_posw (head.posw),
        .width     (width_q),
        .out       (cmp_out)
    );
endmodule

// File: rtl/scmp_checker.sv
module scmp_checker #(
    parameter int PTR_W = 2,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             cmp_out,
    input logic [CNT_W-1:0] event_count,
    input logic             consume,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [PTR_W-1:0] wr_ptr
);
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (event_count == '0 && !cmp_out)); // R12

    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr == wr_ptr) |-> !consume); // R2

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (!enable || event_count == $past(event_count) + CNT_W'(1))); // R3

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !consume) |=> (!enable || $stable(event_count))); // R10

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !consume) |=> (!enable || $stable(rd_ptr))); // R5
endmodule

bind stream_cmp_engine scmp_checker #(.PTR_W(PTR_W), .CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .cmp_out     (cmp_out),
    .event_count (event_count),
    .consume     (consume),
    .rd_ptr      (rd_ptr),
    .wr_ptr      (wr_ptr)
);

// File: tb/stream_cmp_engine_tb_top.sv
`timescale 1ns/1ps
module stream_cmp_engine_tb_top;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          wr_en = 1'b0;
    logic [PW-1:0] wr_addr = '0;
    logic [1:0]    wr_kind = '0;
    logic          wr_dir = 1'b0;
    logic          wr_posw = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [PW-1:0] wr_ptr = '0;
    logic [63:0]   pos_a = '0;
    logic [63:0]   pos_b = '0;
    logic          src_sel = 1'b0;
    logic          cmp_out;
    logic [15:0]   event_count;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [PW-1:0] wp = '0;
    logic [15:0]   exp_cnt = '0;

    stream_cmp_engine #(.DEPTH(4), .TMR_W(16), .CNT_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_kind(wr_kind), .wr_dir(wr_dir),
        .wr_posw(wr_posw), .wr_data(wr_data), .wr_ptr(wr_ptr),
        .pos_a(pos_a), .pos_b(pos_b), .src_sel(src_sel),
        .cmp_out(cmp_out), .event_count(event_count)
    );

    always #2 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=completion");
                $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
                $finish;
            end
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic d, input logic pw, input logic [31:0] v);
        tick;
        wr_en = 1'b1; wr_addr = wp; wr_kind = k; wr_dir = d; wr_posw = pw; wr_data = v;
        tick;
        wr_en = 1'b0;
        wp = wp + PW'(1);
        wr_ptr = wp;
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (cmp_out === 1'b1 && n < 2000) begin
            n++;
            tick;
        end
    endtask

    initial begin
        int n;
        int wlist [6] = '{0, 1, 2, 3, 7, 12};
        logic [63:0] t;
        bit exp_hit;

        // R1: reset state
        tick; tick;
        check("R1 out after reset", 64'(cmp_out), 0);
        check("R1 count after reset", 64'(event_count), 0);
        rst_n = 1'b1; enable = 1'b1;
        tick;
        check("R1 out after release", 64'(cmp_out), 0);
        pos_a = 64'd5;
        push(2'd2, 1'b1, 1'b0, 32'd5);
        tick; exp_cnt++;
        check("R1 upper zero, fire from slot 0", 64'(cmp_out), 1);
        measure_high(n);
        check("R1 width zero gives one cycle (R7)", 64'(n), 1);
        check("R1 count", 64'(event_count), 64'(exp_cnt));

        // R2: written but not advanced
        pos_a = 64'd100;
        tick;
        wr_en = 1'b1; wr_addr = wp; wr_kind = 2'd2; wr_dir = 1'b1; wr_posw = 1'b0; wr_data = 32'd50;
        tick; wr_en = 1'b0;
        tick; tick;
        check("R2 empty out", 64'(cmp_out), 0);
        check("R2 empty count", 64'(event_count), 64'(exp_cnt));
        wp = wp + PW'(1); wr_ptr = wp;
        tick; exp_cnt++;
        check("R2 fires after advance", 64'(cmp_out), 1);
        tick; tick;

        // R7, R5: timed width sweep
        foreach (wlist[i]) begin
            push(2'd0, 1'b0, 1'b0, 32'(wlist[i])); exp_cnt++;
            pos_a = 64'd999;
            push(2'd2, 1'b1, 1'b0, 32'd1000);
            tick;
            check("R5 waits below target", 64'(cmp_out), 0);
            pos_a = 64'd1000;
            tick; exp_cnt++;
            check("R5 fires at target", 64'(cmp_out), 1);
            measure_high(n);
            check("R7 timed width", 64'(n), (wlist[i] == 0) ? 64'd1 : 64'(wlist[i]));
            check("R4 R3 count", 64'(event_count), 64'(exp_cnt));
        end

        // R5, R10: direction sweep and jitter
        push(2'd0, 1'b0, 1'b0, 32'd1); exp_cnt++;
        for (int dir = 0; dir < 2; dir++) begin
            for (int d = 0; d < 5; d++) begin
                t = 64'd20000 + 64'(dir * 100);
                pos_a = t - 64'd2 + 64'(d);
                exp_hit = (dir == 1) ? (d >= 2) : (d < 2);
                push(2'd2, dir[0], 1'b0, t[31:0]);
                tick;
                if (exp_hit) begin
                    exp_cnt++;
                    check("R5 direction immediate", 64'(cmp_out), 1);
                end else begin
                    check("R5 direction wait", 64'(cmp_out), 0);
                    check("R5 direction wait count", 64'(event_count), 64'(exp_cnt));
                    pos_a = (dir == 1) ? t : t - 64'd1;
                    tick; exp_cnt++;
                    check("R5 direction late fire", 64'(cmp_out), 1);
                end
                tick;
                pos_a = (dir == 1) ? t - 64'd1 : t; tick;
                pos_a = (dir == 1) ? t : t - 64'd1; tick;
                check("R10 jitter out", 64'(cmp_out), 0);
                check("R10 jitter count", 64'(event_count), 64'(exp_cnt));
            end
        end

        // R8: retrigger
        push(2'd0, 1'b0, 1'b0, 32'd10); exp_cnt++;
        pos_a = 64'd2999;
        push(2'd2, 1'b1, 1'b0, 32'd3000);
        push(2'd2, 1'b1, 1'b0, 32'd3001);
        pos_a = 64'd3000;
        tick; exp_cnt++;
        check("R8 first fire", 64'(cmp_out), 1);
        tick; tick; tick;
        pos_a = 64'd3001;
        tick; exp_cnt++;
        measure_high(n);
        check("R8 restarted width", 64'(n), 10);

        // R9: position width
        pos_a = 64'd3999;
        push(2'd2, 1'b1, 1'b1, 32'd4000);
        push(2'd2, 1'b1, 1'b1, 32'd4100);
        pos_a = 64'd4000;
        tick; exp_cnt++;
        check("R9 assert", 64'(cmp_out), 1);
        for (int i = 0; i < 20; i++) tick;
        check("R9 held beyond timer", 64'(cmp_out), 1);
        pos_a = 64'd4099; tick;
        check("R9 held before negate", 64'(cmp_out), 1);
        pos_a = 64'd4100; tick; exp_cnt++;
        check("R9 negate", 64'(cmp_out), 0);

        // R6: upper half persistence
        push(2'd1, 1'b0, 1'b0, 32'd1); exp_cnt++;
        pos_a = 64'h0000_0000_FFFF_FFFF;
        push(2'd2, 1'b1, 1'b0, 32'h10);
        tick; tick;
        check("R6 below assembled target", 64'(cmp_out), 0);
        pos_a = 64'h1_0000_0010; tick; exp_cnt++;
        check("R6 assembled fire", 64'(cmp_out), 1);
        measure_high(n);
        pos_a = 64'h1_0000_001F;
        push(2'd2, 1'b1, 1'b0, 32'h20);
        tick; tick;
        check("R6 reused upper wait", 64'(cmp_out), 0);
        pos_a = 64'h1_0000_0020; tick; exp_cnt++;
        check("R6 reused upper fire", 64'(cmp_out), 1);
        measure_high(n);
        check("R6 count", 64'(event_count), 64'(exp_cnt));

        // R13: rollover
        push(2'd1, 1'b0, 1'b0, 32'hFFFF_FFFF); exp_cnt++;
        push(2'd0, 1'b0, 1'b0, 32'd1); exp_cnt++;
        pos_a = 64'd1;
        push(2'd2, 1'b1, 1'b0, 32'hFFFF_FFFF);
        tick; exp_cnt++;
        check("R13 1 >= -1", 64'(cmp_out), 1);
        push(2'd1, 1'b0, 1'b0, 32'h8000_0000); exp_cnt++;
        pos_a = 64'h7FFF_FFFF_FFFF_FFFF;
        push(2'd2, 1'b1, 1'b0, 32'h0);
        tick; tick;
        check("R13 below signed edge", 64'(cmp_out), 0);
        pos_a = 64'h8000_0000_0000_0000; tick; exp_cnt++;
        check("R13 at signed edge", 64'(cmp_out), 1);
        tick;

        // R11: source select
        push(2'd1, 1'b0, 1'b0, 32'd0); exp_cnt++;
        pos_a = 64'd600; pos_b = 64'd400; src_sel = 1'b1;
        push(2'd2, 1'b1, 1'b0, 32'd500);
        tick; tick;
        check("R11 secondary below", 64'(cmp_out), 0);
        src_sel = 1'b0; tick; exp_cnt++;
        check("R11 primary fires", 64'(cmp_out), 1);
        tick;

        // R4: no-op kind
        push(2'd3, 1'b1, 1'b1, 32'h0);
        tick; exp_cnt++;
        check("R4 no-op consumed", 64'(event_count), 64'(exp_cnt));
        check("R4 no-op output", 64'(cmp_out), 0);

        // R12: disable clears, keeps upper and width
        push(2'd1, 1'b0, 1'b0, 32'd2); exp_cnt++;
        pos_a = 64'h2_0000_0800;
        push(2'd2, 1'b1, 1'b1, 32'h700);
        tick; exp_cnt++;
        check("R12 held before disable", 64'(cmp_out), 1);
        enable = 1'b0; wp = '0; wr_ptr = '0;
        tick;
        check("R12 out cleared", 64'(cmp_out), 0);
        check("R12 count cleared", 64'(event_count), 0);
        enable = 1'b1; exp_cnt = '0;
        pos_a = 64'h2_0000_0004;
        push(2'd2, 1'b0, 1'b0, 32'd5);
        tick; exp_cnt++;
        check("R12 upper kept, rd from slot 0", 64'(cmp_out), 1);
        measure_high(n);
        check("R12 width kept", 64'(n), 1);

        // R3: wrap of event count
        enable = 1'b0; wp = '0; wr_ptr = '0;
        for (int s = 0; s < 4; s++) begin
            tick;
            wr_en = 1'b1; wr_addr = PW'(s); wr_kind = 2'd3; wr_data = '0;
        end
        tick; wr_en = 1'b0;
        enable = 1'b1;
        for (int i = 0; i < 65536; i++) begin
            tick;
            if (i == 65535) check("R3 count at 0xFFFF", 64'(event_count), 64'hFFFF);
            wp = wp + PW'(1); wr_ptr = wp;
        end
        tick;
        check("R3 count wraps to 0", 64'(event_count), 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule